// File: doc/BRIEF.md
# Two-Wire Slave Front End with 64-Byte Register Space

This block sits between the two-wire serial bus pins of a small timekeeping chip and its byte-wide register space. It oversamples the bus clock and data lines with a fast system clock, recognises start, repeated start and stop conditions, compares the first byte of each transfer against a fixed 7-bit device address, and acknowledges every byte it accepts. Data moves through a 6-bit location pointer that advances by one after each byte.

A bus master writes by sending the device address with the direction bit clear, then one byte that loads the pointer, then any number of data bytes stored at consecutive locations. A master reads either by loading the pointer this way and issuing a repeated start with the direction bit set, or by addressing the device for reading at once, in which case data comes from wherever the pointer was left. The register space is held in a 64 x 8 array laid out for block RAM. A handful of bit positions in the low locations are fixed at zero.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The device answers only to address 7'b1101000 (byte 0xD0 to write, 0xD1 to read), pulling the acknowledge bit low; any other address gets no acknowledge, and the rest of that transfer is ignored (no bytes are stored and none are acknowledged) until the next start.
- R2: In a write transfer the first byte after the address loads the pointer with its low 6 bits only, so 0x41 selects location 0x01.
- R3: The pointer advances by one after every byte read or written and wraps from 0x3F to 0x00.
- R4: Each data byte after the pointer byte of a write transfer is stored at the pointer and acknowledged.
- R5: Read bytes are shifted out most significant bit first from the pointer location; a read after a pointer write and a repeated start starts at the loaded pointer, and a read with no pointer write continues at the current pointer.
- R6: The acknowledge is held low through the 9th clock pulse of each accepted byte and released after its falling edge; the slave changes its data-line drive only while the bus clock is low.
- R7: A not-acknowledge from the master after a read byte ends the read: the slave leaves the data line released for all later clock pulses until a start or stop.
- R8: A start or stop arriving in the middle of a byte abandons that byte without storing it; a new start always begins a fresh address phase.
- R9: Fixed-zero bits read 0 whatever was written: location 0x01 bit 7, 0x02 bit 7, 0x03 bits 7..3, 0x04 bits 7..6, 0x05 bits 7..5, 0x07 bits 6, 3 and 2.
- R10: After reset the data line is released and the pointer is 0x00; register contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it (open-drain enable) |

## Verification
The hardest conditions to reach from the pins are the abandoned transfers: a start or stop cut into a half-sent byte, and a read that the master stops with a not-acknowledge while it keeps clocking. The bench has a bit-level bus master that can stop after any number of bits and can clock whole bytes after a not-acknowledge, and it then reads the affected locations back through ordinary transfers to show that nothing was stored and the line stayed released. The pointer wrap is reached by loading 0x3F and writing across the boundary, and survival of contents across reset is shown by reading location 0 directly after a reset pulse.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } xfer_state_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_PTR,
    K_DATA
  } byte_kind_t;

  // Writable bits per location; cleared bits are fixed at zero.
  function automatic logic [7:0] keep_mask(input logic [5:0] loc);
    case (loc)
      6'h01:   keep_mask = 8'h7F;
      6'h02:   keep_mask = 8'h7F;
      6'h03:   keep_mask = 8'h07;
      6'h04:   keep_mask = 8'h3F;
      6'h05:   keep_mask = 8'h1F;
      6'h07:   keep_mask = 8'hB3;
      default: keep_mask = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_hit,
  output logic stop_hit
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_hit = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_hit  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cr_store.sv
module i2cr_store
  import i2cr_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] raddr_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata & keep_mask(waddr);
    rdata   <= mem[raddr];
    raddr_q <= raddr;
  end

  AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~keep_mask(raddr_q)) == '0);  // R9

endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
  import i2cr_pkg::*;
#(
  parameter int          AW       = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h68
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_hit,
  input  logic          stop_hit,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] ptr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic          sda_oe
);
  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);

  xfer_state_t   state;
  byte_kind_t    kind;
  logic          rw_q, mack_q, drive_q;
  logic [CW-1:0] bitcnt;
  logic [7:0]    shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind    <= K_DEV;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      drive_q <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      we      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
    end else begin
      we <= 1'b0;
      if (start_hit) begin
        state   <= ST_RX;
        kind    <= K_DEV;
        bitcnt  <= '0;
        drive_q <= 1'b0;
      end else if (stop_hit) begin
        state   <= ST_IDLE;
        bitcnt  <= '0;
        drive_q <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt < CW'(BITS)) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == CW'(BITS)) begin
              bitcnt <= '0;
              case (kind)
                K_DEV: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    rw_q    <= shreg[0];
                    drive_q <= 1'b1;
                    state   <= ST_ACK;
                  end else begin
                    state <= ST_WAIT;
                  end
                end
                K_PTR: begin
                  ptr     <= shreg[AW-1:0];
                  drive_q <= 1'b1;
                  state   <= ST_ACK;
                end
                default: begin
                  we      <= 1'b1;
                  waddr   <= ptr;
                  wdata   <= shreg;
                  ptr     <= ptr + 1'b1;
                  drive_q <= 1'b1;
                  state   <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (kind == K_DEV && rw_q) begin
                shreg   <= rdata;
                drive_q <= ~rdata[7];
                ptr     <= ptr + 1'b1;
                state   <= ST_TX;
              end else begin
                drive_q <= 1'b0;
                kind    <= (kind == K_DEV) ? K_PTR : K_DATA;
                state   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == CW'(BITS - 1)) begin
                drive_q <= 1'b0;
                state   <= ST_TXACK;
              end else begin
                shreg   <= {shreg[6:0], 1'b0};
                drive_q <= ~shreg[6];
                bitcnt  <= bitcnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mack_q) begin
                shreg   <= rdata;
                drive_q <= ~rdata[7];
                ptr     <= ptr + 1'b1;
                state   <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = drive_q;

  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && $past(state) == ST_RX && $past(kind) == K_DEV)
      |-> $past(shreg[7:1]) == DEV_ADDR);  // R1

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TXACK && scl_fall && mack_q && ptr == '1 && !start_hit && !stop_hit)
      |=> ptr == '0);  // R3

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (drive_q != $past(drive_q) && !$past(start_hit) && !$past(stop_hit))
      |-> !$past(scl_s));  // R6

  AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !drive_q);  // R7

  AST_START_FRESH: assert property (@(posedge clk) disable iff (rst)
    start_hit |=> (state == ST_RX && kind == K_DEV && bitcnt == '0));  // R8

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2cr_pkg::*;
#(
  parameter int         AW          = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h68
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_hit, stop_hit;
  logic [AW-1:0] ptr, waddr;
  logic          we;
  logic [7:0]    wdata, rdata;

  i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_hit (start_hit),
    .stop_hit  (stop_hit)
  );

  i2cr_engine #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_hit (start_hit),
    .stop_hit  (stop_hit),
    .rdata     (rdata),
    .ptr       (ptr),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .sda_oe    (sda_oe)
  );

  i2cr_store #(.AW(AW), .DW(8)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (ptr),
    .rdata (rdata)
  );

endmodule

// File: tb/i2c_regfile_slave_test.sv
module i2c_regfile_slave_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, r6_viol = 0;
  logic [7:0] model [64];
  int ptr_m = 0;
  logic prev_oe = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_regfile_slave uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  // Per-clock monitor: the slave may change its drive only while the clock is low.
  always @(negedge clk) begin
    if (!rst) begin
      if (sda_oe !== prev_oe && scl_m) r6_viol++;
      prev_oe = sda_oe;
    end
  end

  function automatic logic [7:0] keep(input int loc);
    case (loc)
      1, 2:    return 8'h7F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h1F;
      7:       return 8'hB3;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0;
    end
    tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit chk_rel, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0;
    end
    sda_m = 1; tick(Q); scl_m = 1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl_m = 0; tick(Q);
    if (chk_rel && ack) check("R6 ack released after 9th pulse", sda_oe, 0);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1; tick(Q); b = {b[6:0], sda_line}; tick(Q); scl_m = 0;
    end
    tick(Q); sda_m = nack; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q); sda_m = 1;
  endtask

  task automatic model_write(input logic [7:0] d);
    model[ptr_m] = d & keep(ptr_m);
    ptr_m = (ptr_m + 1) % 64;
  endtask

  task automatic read_expect(input string req, input bit nack);
    logic [7:0] b;
    recv_byte(nack, b);
    check(req, b, model[ptr_m]);
    ptr_m = (ptr_m + 1) % 64;
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    tick(4);
    rst = 0;
    tick(4);
    check("R10 released after reset", sda_oe, 0);

    // Write pointer 0 and four bytes.
    bus_start();
    send_byte(8'hD0, 1, ack); check("R1 write address acked", ack, 1);
    send_byte(8'h00, 1, ack); check("R2 pointer byte acked", ack, 1); ptr_m = 0;
    begin
      logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
      for (int i = 0; i < 4; i++) begin
        send_byte(d[i], 1, ack); check("R4 data byte acked", ack, 1);
        model_write(d[i]);
      end
    end
    bus_stop();

    // Pointer value 0x41 selects location 0x01.
    bus_start();
    send_byte(8'hD0, 1, ack);
    send_byte(8'h41, 1, ack); ptr_m = 1;
    send_byte(8'hAB, 1, ack); model_write(8'hAB);
    bus_stop();

    // Pointer write, repeated start, read three bytes.
    bus_start();
    send_byte(8'hD0, 1, ack);
    send_byte(8'h40, 1, ack); ptr_m = 0;
    bus_rstart();
    send_byte(8'hD1, 0, ack); check("R1 read address acked", ack, 1);
    read_expect("R5 read loc0", 0);
    read_expect("R2 R9 read loc1 (0x41 wrote here)", 0);
    read_expect("R5 read loc2", 1);
    bus_stop();

    // Direct read continues at the current pointer (3).
    bus_start();
    send_byte(8'hD1, 0, ack);
    read_expect("R5 direct read continues", 1);
    bus_stop();

    // Wrap from 0x3F to 0x00.
    bus_start();
    send_byte(8'hD0, 1, ack);
    send_byte(8'h3F, 1, ack); ptr_m = 63;
    send_byte(8'hC1, 1, ack); model_write(8'hC1);
    send_byte(8'hC2, 1, ack); model_write(8'hC2);
    bus_stop();
    bus_start();
    send_byte(8'hD0, 1, ack);
    send_byte(8'h3F, 1, ack); ptr_m = 63;
    bus_rstart();
    send_byte(8'hD1, 0, ack);
    read_expect("R3 read loc 0x3F", 0);
    read_expect("R3 read wrapped to loc 0", 1);
    bus_stop();

    // Foreign address: no ack, later bytes ignored.
    bus_start();
    send_byte(8'hA0, 0, ack); check("R1 foreign address not acked", ack, 0);
    send_byte(8'h02, 0, ack); check("R1 later byte not acked", ack, 0);
    send_byte(8'h99, 0, ack);
    bus_stop();
    bus_start();
    send_byte(8'hD0, 1, ack);
    send_byte(8'h02, 1, ack); ptr_m = 2;
    bus_rstart();
    send_byte(8'hD1, 0, ack);
    read_expect("R1 foreign transfer stored nothing", 1);
    bus_stop();

    // NACK ends the read; further clocking gets no drive.
    bus_start();
    send_byte(8'hD0, 1, ack);
    send_byte(8'h00, 1, ack); ptr_m = 0;
    bus_rstart();
    send_byte(8'hD1, 0, ack);
    read_expect("R5 read before nack", 1);
    recv_byte(1, b); check("R7 no drive after nack", b, 8'hFF);
    bus_stop();

    // Stop cuts a byte: nothing stored at 0x10.
    bus_start();
    send_byte(8'hD0, 1, ack);
    send_byte(8'h10, 1, ack); ptr_m = 16;
    send_byte(8'h5A, 1, ack); model_write(8'h5A);
    bus_stop();
    bus_start();
    send_byte(8'hD0, 1, ack);
    send_byte(8'h10, 1, ack);
    send_bits(8'hF0, 4);
    bus_stop();
    // Start cuts a byte: fresh address phase.
    bus_start();
    send_byte(8'hD0, 1, ack);
    send_bits(8'h33, 5);
    bus_rstart();
    send_byte(8'hD0, 1, ack); check("R8 fresh address after mid-byte start", ack, 1);
    send_byte(8'h10, 1, ack); ptr_m = 16;
    bus_rstart();
    send_byte(8'hD1, 0, ack);
    read_expect("R8 cut byte not stored", 1);
    bus_stop();

    // Fixed-zero bits.
    bus_start();
    send_byte(8'hD0, 1, ack);
    send_byte(8'h01, 1, ack); ptr_m = 1;
    for (int i = 1; i <= 7; i++) begin
      send_byte(8'hFF, 1, ack); model_write(8'hFF);
    end
    bus_rstart();
    send_byte(8'hD0, 1, ack);
    send_byte(8'h01, 1, ack); ptr_m = 1;
    bus_rstart();
    send_byte(8'hD1, 0, ack);
    for (int i = 1; i <= 7; i++) read_expect("R9 fixed-zero bits", i == 7);
    bus_stop();

    // Reset: pointer to 0, contents kept.
    tick(2);
    rst = 1; tick(3); rst = 0; tick(3);
    ptr_m = 0;
    check("R10 released after second reset", sda_oe, 0);
    bus_start();
    send_byte(8'hD1, 0, ack);
    read_expect("R10 pointer zero, contents kept", 1);
    bus_stop();

    check("R6 drive changed only while clock low", r6_viol, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule